// File: doc/BRIEF.md
# SPI Master Interrupt Status Unit

This unit gathers the interrupt sources of an SPI master that moves bytes through a transmit FIFO and a receive FIFO. Its inputs are the two FIFO fill counts, the two FIFO full flags and three single-cycle event pulses: transmit underflow, receive overflow and mode fail. From these it keeps a 7-bit status word and drives one level-sensitive interrupt line.

Three status bits are sticky event flags. They stay set until software clears them. The other four bits are level flags. The unit rebuilds them every cycle from the FIFO inputs and from two programmable thresholds.

Software reaches the unit through a simple register port. Reading the status word returns it and clears it. A status bit can also be cleared by writing a one to it. The interrupt mask has no direct write path: one address sets mask bits and another clears them. A linear-read mode input freezes the status word and the interrupt line while the controller fetches memory on its own.

Top module: `spi_irq_status`

## Requirements
- R1: The status bits are: bit 0 receive overflow, bit 1 mode fail, bit 6 transmit underflow. Each of these is set one clock edge after its event input pulses high. It stays set until a register-port clear.
- R2: Bit 3 is the transmit-full input and bit 5 is the receive-full input, both as sampled at the previous clock edge. Neither bit holds its value once its input falls.
- R3: Bit 4 is set when the receive count is at least the RX threshold. Bit 2 is set when the transmit count is strictly below the TX threshold. Both are evaluated at each clock edge.
- R4: The TX threshold is at address 4 and the RX threshold is at address 5. Both are read/write, use the low CNT_W data bits, and reset to 1.
- R5: A read of address 0 returns the status word in data bits 6:0 with all upper bits zero. The status word is cleared at that clock edge.
- R6: A write to address 0 clears exactly the status bits whose data bits are one.
- R7: An event pulse in the same cycle as a read-clear or a write-one-to-clear of its bit leaves the bit set.
- R8: Writing ones to address 1 sets those mask bits. Writing ones to address 2 clears them. The mask reads at address 3, and writes to address 3 change nothing. Addresses 1 and 2 read as zero.
- R9: The interrupt output is registered. At each clock edge it takes the OR of (mask AND status) as it stood before that edge. This puts it one cycle behind any status or mask change.
- R10: While the linear-read input is high, the status word ignores events, level changes and clears, and the interrupt output holds its value. Mask and threshold writes still take effect.
- R11: Reset clears the status word, the mask and the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lin_mode_i | input | 1 | Linear-read mode; freezes status and interrupt |
| tx_count_i | input | CNT_W | Transmit FIFO fill count |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_full_i | input | 1 | Receive FIFO full |
| evt_tx_underflow_i | input | 1 | Transmit underflow pulse |
| evt_rx_overflow_i | input | 1 | Receive overflow pulse |
| evt_mode_fail_i | input | 1 | Mode fail pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational from the address |
| irq_o | output | 1 | Level interrupt output |

## Verification
An event or FIFO input presented before a clock edge shows in the status word after that edge. The bench therefore drives inputs on a falling edge, lets one rising edge pass, and reads on the next falling edge. The interrupt line lags the status word and the mask by one more edge, so every interrupt check is made on two successive falling edges: the first must still show the old level and the second the new one. Read data is combinational, so it is sampled shortly after the strobe is raised. The clear it causes is then confirmed by a second read after the edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int STAT_W = 7;

  localparam int B_RX_OVF    = 0;
  localparam int B_MODE_FAIL = 1;
  localparam int B_TX_LOW    = 2;
  localparam int B_TX_FULL   = 3;
  localparam int B_RX_AVAIL  = 4;
  localparam int B_RX_FULL   = 5;
  localparam int B_TX_UNDF   = 6;

  localparam logic [STAT_W-1:0] STICKY_BITS =
    STAT_W'((1 << B_RX_OVF) | (1 << B_MODE_FAIL) | (1 << B_TX_UNDF));

  typedef enum logic [2:0] {
    A_STAT  = 3'd0,
    A_MSET  = 3'd1,
    A_MCLR  = 3'd2,
    A_MASK  = 3'd3,
    A_TXTHR = 3'd4,
    A_RXTHR = 3'd5
  } reg_sel_e;

  // Places the three event pulses at their status positions.
  function automatic logic [STAT_W-1:0] event_vector(input logic undf,
                                                      input logic ovf,
                                                      input logic mfail);
    logic [STAT_W-1:0] v;
    v = '0;
    v[B_TX_UNDF]   = undf;
    v[B_RX_OVF]    = ovf;
    v[B_MODE_FAIL] = mfail;
    return v;
  endfunction

endpackage

// File: rtl/spi_irq_stat_core.sv
module spi_irq_stat_core
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic [CNT_W-1:0]  tx_thr_i,
  input  logic [CNT_W-1:0]  rx_thr_i,
  input  logic [STAT_W-1:0] evt_vec_i,
  input  logic [STAT_W-1:0] clr_vec_i,
  output logic [STAT_W-1:0] stat_o
);

  // Level part of the status word, rebuilt from FIFO state.
  function automatic logic [STAT_W-1:0] level_bits(
    input logic [CNT_W-1:0] txc, input logic [CNT_W-1:0] rxc,
    input logic txf, input logic rxf,
    input logic [CNT_W-1:0] txt, input logic [CNT_W-1:0] rxt);
    logic [STAT_W-1:0] v;
    v = '0;
    v[B_TX_LOW]   = (txc < txt);
    v[B_TX_FULL]  = txf;
    v[B_RX_AVAIL] = (rxc >= rxt);
    v[B_RX_FULL]  = rxf;
    return v;
  endfunction

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] live_w;
  logic [STAT_W-1:0] kept_w;
  logic [STAT_W-1:0] stat_d;

  always_comb begin
    live_w = level_bits(tx_count_i, rx_count_i, tx_full_i, rx_full_i,
                        tx_thr_i, rx_thr_i);
    // Event set wins over a clear arriving in the same cycle.
    kept_w = ((stat_q & ~clr_vec_i) | evt_vec_i) & STICKY_BITS;
    stat_d = freeze_i ? stat_q : (kept_w | live_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [STAT_W-1:0] mask_o,
  output logic [CNT_W-1:0]  tx_thr_o,
  output logic [CNT_W-1:0]  rx_thr_o,
  output logic [STAT_W-1:0] clr_vec_o
);

  localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(1);

  logic hit_stat, hit_mset, hit_mclr, hit_mask, hit_txthr, hit_rxthr;
  logic [STAT_W-1:0] wbits;
  logic [STAT_W-1:0] mask_q;
  logic [CNT_W-1:0]  tx_thr_q, rx_thr_q;

  assign hit_stat  = (addr_i == ADDR_W'(A_STAT));
  assign hit_mset  = (addr_i == ADDR_W'(A_MSET));
  assign hit_mclr  = (addr_i == ADDR_W'(A_MCLR));
  assign hit_mask  = (addr_i == ADDR_W'(A_MASK));
  assign hit_txthr = (addr_i == ADDR_W'(A_TXTHR));
  assign hit_rxthr = (addr_i == ADDR_W'(A_RXTHR));
  assign wbits     = wdata_i[STAT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_i && hit_mset) begin
      mask_q <= mask_q | wbits;
    end else if (wr_i && hit_mclr) begin
      mask_q <= mask_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= THR_RESET;
      rx_thr_q <= THR_RESET;
    end else if (wr_i) begin
      if (hit_txthr) tx_thr_q <= wdata_i[CNT_W-1:0];
      if (hit_rxthr) rx_thr_q <= wdata_i[CNT_W-1:0];
    end
  end

  // Clear request: a status read clears all, a status write clears its ones.
  always_comb begin
    clr_vec_o = '0;
    if (rd_i && hit_stat)      clr_vec_o = '1;
    else if (wr_i && hit_stat) clr_vec_o = wbits;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_stat)       rdata_o = DATA_W'(stat_i);
    else if (hit_mask)  rdata_o = DATA_W'(mask_q);
    else if (hit_txthr) rdata_o = DATA_W'(tx_thr_q);
    else if (hit_rxthr) rdata_o = DATA_W'(rx_thr_q);
  end

  assign mask_o   = mask_q;
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;

endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
  import spi_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              irq_o
);

  logic irq_q;
  logic pend_w;

  assign pend_w = |(mask_i & stat_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (!freeze_i) irq_q <= pend_w;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lin_mode_i,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic              evt_tx_underflow_i,
  input  logic              evt_rx_overflow_i,
  input  logic              evt_mode_fail_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  logic [STAT_W-1:0] evt_vec_w;
  logic [STAT_W-1:0] clr_vec_w;
  logic [STAT_W-1:0] stat_w;
  logic [STAT_W-1:0] mask_w;
  logic [CNT_W-1:0]  tx_thr_w;
  logic [CNT_W-1:0]  rx_thr_w;

  assign evt_vec_w = event_vector(evt_tx_underflow_i, evt_rx_overflow_i,
                                  evt_mode_fail_i);

  spi_irq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .stat_i    (stat_w),
    .rdata_o   (reg_rdata_o),
    .mask_o    (mask_w),
    .tx_thr_o  (tx_thr_w),
    .rx_thr_o  (rx_thr_w),
    .clr_vec_o (clr_vec_w)
  );

  spi_irq_stat_core #(
    .CNT_W (CNT_W)
  ) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_i   (lin_mode_i),
    .tx_count_i (tx_count_i),
    .rx_count_i (rx_count_i),
    .tx_full_i  (tx_full_i),
    .rx_full_i  (rx_full_i),
    .tx_thr_i   (tx_thr_w),
    .rx_thr_i   (rx_thr_w),
    .evt_vec_i  (evt_vec_w),
    .clr_vec_i  (clr_vec_w),
    .stat_o     (stat_w)
  );

  spi_irq_out out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze_i (lin_mode_i),
    .mask_i   (mask_w),
    .stat_i   (stat_w),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lin_mode_i,
  input logic              tx_full_i,
  input logic              evt_tx_underflow_i,
  input logic              evt_rx_overflow_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_w,
  input logic [STAT_W-1:0] mask_w
);

  logic at_stat, at_mset, at_mclr;
  assign at_stat = (reg_addr_i == ADDR_W'(A_STAT));
  assign at_mset = (reg_addr_i == ADDR_W'(A_MSET));
  assign at_mclr = (reg_addr_i == ADDR_W'(A_MCLR));

  p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode_i && evt_rx_overflow_i) |=> stat_w[B_RX_OVF]);

  p_sticky_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w[B_TX_UNDF] && !(reg_rd_i && at_stat) &&
     !(reg_wr_i && at_stat && reg_wdata_i[B_TX_UNDF])) |=> stat_w[B_TX_UNDF]);

  p_full_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lin_mode_i |=> (stat_w[B_TX_FULL] == $past(tx_full_i)));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode_i && reg_rd_i && at_stat && !evt_rx_overflow_i) |=> !stat_w[B_RX_OVF]);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_stat |-> (reg_rdata_o[DATA_W-1:STAT_W] == '0));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode_i && evt_tx_underflow_i && reg_rd_i && at_stat) |=> stat_w[B_TX_UNDF]);

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && at_mset) |=>
      ((mask_w & $past(reg_wdata_i[STAT_W-1:0])) == $past(reg_wdata_i[STAT_W-1:0])));

  p_mask_ports_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mset || at_mclr) |-> (reg_rdata_o == '0));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lin_mode_i |=> (irq_o == $past(|(mask_w & stat_w))));

  p_freeze_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lin_mode_i |=> ($stable(stat_w) && $stable(irq_o)));

endmodule

bind spi_irq_status spi_irq_status_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk                (clk),
  .rst_n              (rst_n),
  .lin_mode_i         (lin_mode_i),
  .tx_full_i          (tx_full_i),
  .evt_tx_underflow_i (evt_tx_underflow_i),
  .evt_rx_overflow_i  (evt_rx_overflow_i),
  .reg_wr_i           (reg_wr_i),
  .reg_rd_i           (reg_rd_i),
  .reg_addr_i         (reg_addr_i),
  .reg_wdata_i        (reg_wdata_i),
  .reg_rdata_o        (reg_rdata_o),
  .irq_o              (irq_o),
  .stat_w             (stat_w),
  .mask_w             (mask_w)
);

// File: tb/spi_irq_status_tb.sv
module spi_irq_status_tb_top;

  localparam int CNT_W  = 7;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [2:0] AS = 3'd0, AE = 3'd1, AD = 3'd2, AM = 3'd3, AT = 3'd4, AR = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lin_mode = 1'b0;
  logic [CNT_W-1:0] tx_cnt = '0, rx_cnt = '0;
  logic tx_full = 1'b0, rx_full = 1'b0;
  logic e_undf = 1'b0, e_ovf = 1'b0, e_mf = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_irq_status #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lin_mode_i(lin_mode),
    .tx_count_i(tx_cnt), .rx_count_i(rx_cnt),
    .tx_full_i(tx_full), .rx_full_i(rx_full),
    .evt_tx_underflow_i(e_undf), .evt_rx_overflow_i(e_ovf), .evt_mode_fail_i(e_mf),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [CNT_W-1:0] txc;
    logic [CNT_W-1:0] rxc;
    logic             txf;
    logic             rxf;
    logic [6:0]       exp;
  } vec_t;

  // Thresholds TX=4, RX=3. bit2: txc<4, bit3: txf, bit4: rxc>=3, bit5: rxf.
  localparam vec_t VECS [6] = '{
    '{txc: 7'd3,  rxc: 7'd2,  txf: 1'b0, rxf: 1'b0, exp: 7'h04},
    '{txc: 7'd4,  rxc: 7'd3,  txf: 1'b0, rxf: 1'b0, exp: 7'h10},
    '{txc: 7'd64, rxc: 7'd64, txf: 1'b1, rxf: 1'b1, exp: 7'h38},
    '{txc: 7'd0,  rxc: 7'd0,  txf: 1'b0, rxf: 1'b0, exp: 7'h04},
    '{txc: 7'd5,  rxc: 7'd0,  txf: 1'b1, rxf: 1'b0, exp: 7'h08},
    '{txc: 7'd4,  rxc: 7'd2,  txf: 1'b0, rxf: 1'b1, exp: 7'h20}
  };

  task automatic check(input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; strobe spans one rising edge.
  task automatic rd_chk(input logic [2:0] a, input logic [DATA_W-1:0] exp,
                        input string tag);
    rd = 1'b1; addr = a;
    #1 check(tag, rdata, exp);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input logic u, input logic o, input logic m);
    e_undf = u; e_ovf = o; e_mf = m;
    @(negedge clk);
    e_undf = 1'b0; e_ovf = 1'b0; e_mf = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    #1 check(tag, DATA_W'(irq), DATA_W'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11: reset state
    irq_chk(1'b0, "R11 irq in reset");
    rd_chk(AM, 0, "R11 mask in reset");
    rst_n = 1'b1;
    rd_chk(AS, 0, "R11 status after reset");
    rd_chk(AS, 32'h04, "R3 tx below threshold 1");
    rd_chk(AT, 1, "R4 tx threshold reset");
    rd_chk(AR, 1, "R4 rx threshold reset");
    wr_reg(AT, 4);
    wr_reg(AR, 3);
    rd_chk(AT, 4, "R4 tx threshold write");
    rd_chk(AR, 3, "R4 rx threshold write");

    // Vector walk over level bits
    foreach (VECS[i]) begin
      tx_cnt = VECS[i].txc; rx_cnt = VECS[i].rxc;
      tx_full = VECS[i].txf; rx_full = VECS[i].rxf;
      @(negedge clk);
      rd_chk(AS, DATA_W'(VECS[i].exp), "R2 R3 level vector");
    end

    // quiet level state: nothing set
    tx_cnt = 7'd4; rx_cnt = 7'd0; tx_full = 1'b0; rx_full = 1'b0;
    @(negedge clk);
    rd_chk(AS, 0, "R2 full bits not retained");

    pulse(1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    rd_chk(AS, 32'h01, "R1 overflow sticky");
    rd_chk(AS, 0, "R5 cleared by read");

    pulse(1'b1, 1'b0, 1'b1);
    wr_reg(AS, 32'h0000_0002);
    rd_chk(AS, 32'h40, "R6 write-one clears only bit1");
    rd_chk(AS, 0, "R5 clear after read");

    // R7: event together with read-clear
    rd = 1'b1; addr = AS; e_undf = 1'b1;
    @(negedge clk);
    rd = 1'b0; e_undf = 1'b0;
    rd_chk(AS, 32'h40, "R7 event beats read clear");
    // R7: event together with write-one-clear
    wr = 1'b1; addr = AS; wdata = 32'h40; e_undf = 1'b1;
    @(negedge clk);
    wr = 1'b0; e_undf = 1'b0;
    rd_chk(AS, 32'h40, "R7 event beats w1c");

    // R8 mask access
    wr_reg(AE, 32'h41);
    rd_chk(AM, 32'h41, "R8 enable sets");
    wr_reg(AD, 32'h01);
    rd_chk(AM, 32'h40, "R8 disable clears");
    wr_reg(AM, 32'h7F);
    rd_chk(AM, 32'h40, "R8 mask write ignored");
    rd_chk(AE, 0, "R8 enable reads zero");
    rd_chk(AD, 0, "R8 disable reads zero");

    // R9 irq latency from status
    pulse(1'b1, 1'b0, 1'b0);
    irq_chk(1'b0, "R9 irq one cycle after status");
    @(negedge clk);
    irq_chk(1'b1, "R9 irq raised");
    rd_chk(AS, 32'h40, "R9 status read");
    irq_chk(1'b1, "R9 irq lags clear");
    @(negedge clk);
    irq_chk(1'b0, "R9 irq dropped");
    // R9 irq latency from mask
    tx_full = 1'b1;
    @(negedge clk);
    wr_reg(AE, 32'h08);
    irq_chk(1'b0, "R9 irq lags mask");
    @(negedge clk);
    irq_chk(1'b1, "R9 irq from mask");
    wr_reg(AD, 32'h08);
    tx_full = 1'b0;
    repeat (2) @(negedge clk);
    irq_chk(1'b0, "R9 irq after unmask");

    // R10 freeze
    pulse(1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    irq_chk(1'b1, "R10 irq before freeze");
    lin_mode = 1'b1;
    @(negedge clk);
    wr_reg(AD, 32'h40);
    pulse(1'b0, 1'b1, 1'b0);
    tx_full = 1'b1;
    repeat (2) @(negedge clk);
    irq_chk(1'b1, "R10 irq held");
    rd_chk(AS, 32'h40, "R10 status frozen");
    rd_chk(AS, 32'h40, "R10 read clear ignored");
    tx_full = 1'b0;
    lin_mode = 1'b0;
    @(negedge clk);
    irq_chk(1'b0, "R10 irq resumes");
    rd_chk(AS, 32'h40, "R10 event during freeze dropped");
    rd_chk(AM, 0, "R10 mask write during freeze");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule